// File: doc/BRIEF.md
# SCL Clock Synchronizer

This block produces the clock of an I2C master on an open-drain, wired-AND SCL line. It drives the line low for a programmed number of system clocks, then lets it go and waits until the line actually reads high. Only then does it count the programmed high time. Because the line is the AND of every device on it, the result follows two rules. The longest low time of any participant sets the low phase. The shortest high time sets the high phase. A slave that holds SCL low, for one bit or between bytes, stalls the master until it lets go.

A bit engine sits beside the block. It uses two single-cycle strobes: one marks the moment the master sees SCL go high, and one marks the moment it starts to drive SCL low. The SCL input must already be synchronized to the system clock. Data shifting is not part of this block.

Top module: `scl_clock_sync`

## Requirements
- R1: While `en_i` is 0, `scl_drive_low_o`, `scl_rise_o` and `scl_fall_o` are 0 from the next cycle on. Counting is held in reset, so after re-enable the first low phase lasts the full programmed length.
- R2: The cycle after `en_i` rises, `scl_drive_low_o` is 1 and `scl_fall_o` pulses. Every cycle in which `scl_fall_o` is 1 is also a cycle in which `scl_drive_low_o` is 1.
- R3: Each low phase drives `scl_drive_low_o` for exactly Lc cycles, starting with the `scl_fall_o` cycle, and then releases it. Lc is the effective low count.
- R4: After release, the high count starts only once `scl_i` is sampled 1. `scl_rise_o` pulses in the next cycle. Without stretching, the distance from `scl_fall_o` to `scl_rise_o` is Lc+1 cycles. If another device holds the line low for S cycles from the fall cycle, the distance is max(Lc,S)+1 cycles.
- R5: If the line stays high, `scl_fall_o` follows `scl_rise_o` by exactly Hc cycles, where Hc is the effective high count. The line is driven low again in that cycle.
- R6: If `scl_i` is sampled 0 during the high phase, the block drives low and pulses `scl_fall_o` in the next cycle, and its low count restarts from zero.
- R7: `low_cnt_i` and `high_cnt_i` are 16-bit counts of system clocks. Any value below 4 is treated as 4: Lc = max(low_cnt_i,4) and Hc = max(high_cnt_i,4).
- R8: `scl_rise_o` and `scl_fall_o` are never 1 in the same cycle. `scl_drive_low_o` is 0 whenever `scl_rise_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock generation enable |
| low_cnt_i | input | 16 | Programmed low period, in system clocks |
| high_cnt_i | input | 16 | Programmed high period, in system clocks |
| scl_i | input | 1 | Synchronized SCL line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low; 0 releases it |
| scl_rise_o | output | 1 | One-cycle strobe: SCL seen high, high phase starts |
| scl_fall_o | output | 1 | One-cycle strobe: low phase starts |

## Verification
The hardest situations to reach are those in which the line differs from what the block drives. One is a line still held low after the block's own low count has ended. The other is a line pulled low part way through the high count. The bench models the wired-AND line: it combines the block's drive with a second open-drain driver that it controls cycle by cycle. It aligns that driver to the observed strobes, holding the line for a chosen number of cycles after a fall or pulling it at a chosen cycle after a rise. It then measures the strobe-to-strobe distances. Stretches both shorter and longer than the low count are included, as is a long stall between bytes, to show that a hidden stretch has no effect and a visible one sets the pace.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_phase_e;

  localparam int unsigned NUM_PHASES = 2;
  localparam int unsigned PH_LOW     = 0;
  localparam int unsigned PH_HIGH    = 1;
endpackage

// File: rtl/scl_period_clamp.sv
module scl_period_clamp #(
  parameter int unsigned W       = 16,
  parameter int unsigned MIN_VAL = 4
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] eff_o
);
  localparam logic [W-1:0] MinV = W'(MIN_VAL);

  always_comb begin
    eff_o = (raw_i < MinV) ? MinV : raw_i;
  end
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last_v;

  // limit is at least the clamp minimum, so no underflow
  assign last_v = limit_i - W'(1);
  // >= keeps a lowered limit from letting the count run past it
  assign done_o = (cnt_q >= last_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_sync_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       scl_i,
  input  logic       done_i,
  output scl_phase_e phase_o,
  output logic       clr_o,
  output logic       drive_low_o,
  output logic       rise_o,
  output logic       fall_o
);
  scl_phase_e ph_q, ph_d;
  logic rise_q, fall_q;

  always_comb begin
    ph_d = ph_q;
    if (!en_i) begin
      ph_d = ST_OFF;
    end else begin
      unique case (ph_q)
        ST_OFF:  ph_d = ST_LOW;
        ST_LOW:  if (done_i) ph_d = ST_WAIT;
        // released: hold off until the line really reads high
        ST_WAIT: if (scl_i) ph_d = ST_HIGH;
        // another device pulling low ends our high phase at once
        ST_HIGH: if (!scl_i || done_i) ph_d = ST_LOW;
        default: ph_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= ST_OFF;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rise_q <= (ph_d == ST_HIGH) && (ph_q != ST_HIGH);
      fall_q <= (ph_d == ST_LOW) && (ph_q != ST_LOW);
    end
  end

  assign clr_o       = (ph_d != ph_q) || !en_i;
  assign phase_o     = ph_q;
  assign drive_low_o = (ph_q == ST_LOW);
  assign rise_o      = rise_q;
  assign fall_o      = fall_q;
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import scl_sync_pkg::*;
#(
  parameter int unsigned PERIOD_W   = 16,
  parameter int unsigned MIN_PERIOD = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] low_cnt_i,
  input  logic [PERIOD_W-1:0] high_cnt_i,
  input  logic                scl_i,
  output logic                scl_drive_low_o,
  output logic                scl_rise_o,
  output logic                scl_fall_o
);
  logic [PERIOD_W-1:0] raw_per [NUM_PHASES];
  logic [PERIOD_W-1:0] eff_per [NUM_PHASES];
  logic [PERIOD_W-1:0] limit;
  scl_phase_e          phase;
  logic                cnt_clr, cnt_done;

  assign raw_per[PH_LOW]  = low_cnt_i;
  assign raw_per[PH_HIGH] = high_cnt_i;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_clamp
    scl_period_clamp #(
      .W       (PERIOD_W),
      .MIN_VAL (MIN_PERIOD)
    ) u_clamp (
      .raw_i (raw_per[g]),
      .eff_o (eff_per[g])
    );
  end

  assign limit = (phase == ST_HIGH) ? eff_per[PH_HIGH] : eff_per[PH_LOW];

  scl_phase_counter #(.W(PERIOD_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .limit_i (limit),
    .done_o  (cnt_done)
  );

  scl_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .scl_i       (scl_i),
    .done_i      (cnt_done),
    .phase_o     (phase),
    .clr_o       (cnt_clr),
    .drive_low_o (scl_drive_low_o),
    .rise_o      (scl_rise_o),
    .fall_o      (scl_fall_o)
  );
endmodule

module scl_clock_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_i,
  input logic scl_drive_low_o,
  input logic scl_rise_o,
  input logic scl_fall_o
);
  // R8
  no_dual_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_rise_o && scl_fall_o));

  // R8
  released_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> !scl_drive_low_o);

  // R4
  rise_after_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> $past(scl_i));

  // R2
  fall_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> scl_drive_low_o);

  // R2
  drive_start_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_low_o) |-> scl_fall_o);

  // R1
  off_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_drive_low_o && !scl_rise_o && !scl_fall_o));

  // R6
  pull_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !scl_drive_low_o && !scl_i && !$past(scl_drive_low_o) && $past(scl_i))
      |=> scl_fall_o);
endmodule

bind scl_clock_sync scl_clock_sync_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .scl_i           (scl_i),
  .scl_drive_low_o (scl_drive_low_o),
  .scl_rise_o      (scl_rise_o),
  .scl_fall_o      (scl_fall_o)
);

// File: tb/tb_scl_clock_sync.sv
module tb_scl_clock_sync;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;
  localparam int NVEC = 8;
  // L, H, stretch S, pull P, expected fall->rise, expected rise->fall
  localparam int VEC [NVEC][6] = '{
    '{ 10,  8,   0, 0,  11,  8},  // R3 R5 plain
    '{  4,  4,   0, 0,   5,  4},  // R3 R5 minimum legal
    '{  2,  1,   0, 0,   5,  4},  // R7 clamp both
    '{  6, 12,  15, 0,  16, 12},  // R4 bit-level stretch
    '{  6, 12,   3, 0,   7, 12},  // R4 hidden stretch
    '{  8, 20,   0, 5,   9,  5},  // R6 early pull
    '{  5,  9, 120, 1, 121,  1},  // R4 byte stall, R6 pull at once
    '{300,  7,   0, 0, 301,  7}   // R3 long low
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] low_cnt = 16'd10;
  logic [15:0] high_cnt = 16'd8;
  logic        ext_hold = 1'b0;
  logic        scl_line;
  logic        drive_low, rise, fall;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND line: block and a second open-drain device
  assign scl_line = ~drive_low & ~ext_hold;

  scl_clock_sync dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .en_i            (en),
    .low_cnt_i       (low_cnt),
    .high_cnt_i      (high_cnt),
    .scl_i           (scl_line),
    .scl_drive_low_o (drive_low),
    .scl_rise_o      (rise),
    .scl_fall_o      (fall)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT) begin
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG_LIMIT);
      errors = errors + 1;
      checks = checks + 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!fall);
  endtask

  // starts at the next fall; returns fall->rise and rise->fall distances
  task automatic measure(input int s, input int p, input int lc,
                         output int lo, output int hi);
    int n;
    bit got;
    wait_fall();
    ext_hold = (s > 0);
    n = 0;
    got = 0;
    while (!got) begin
      @(negedge clk);
      n++;
      if (s > lc && n == lc + 1) begin
        // R4: own drive released while the line is still held
        chk("R4 released during stretch", {31'd0, drive_low} + {31'd0, rise}, 0);
      end
      if (rise) got = 1;
      else if (n >= s) ext_hold = 1'b0;
    end
    lo = n;
    ext_hold = (p == 1);
    n = 0;
    got = 0;
    while (!got) begin
      @(negedge clk);
      n++;
      if (fall) got = 1;
      else ext_hold = (p > 1 && n == p - 1);
    end
    ext_hold = 1'b0;
    hi = n;
  endtask

  initial begin
    int lo, hi, lc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset drive", {31'd0, drive_low}, 0);
    chk("R1 reset rise", {31'd0, rise}, 0);
    chk("R1 reset fall", {31'd0, fall}, 0);
    rst_n = 1'b1;
    // R1 disabled after reset: nothing happens
    begin
      int act = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        act += int'(drive_low) + int'(rise) + int'(fall);
      end
      chk("R1 idle while disabled", act, 0);
    end
    // R2 enable starts a low phase next cycle
    en = 1'b1;
    @(negedge clk);
    chk("R2 drive after enable", {31'd0, drive_low}, 1);
    chk("R2 fall after enable", {31'd0, fall}, 1);

    for (int v = 0; v < NVEC; v++) begin
      low_cnt  = 16'(VEC[v][0]);
      high_cnt = 16'(VEC[v][1]);
      lc = (VEC[v][0] < 4) ? 4 : VEC[v][0];
      wait_fall();
      measure(VEC[v][2], VEC[v][3], lc, lo, hi);
      chk($sformatf("R3 R4 R7 vec%0d low span", v), lo, VEC[v][4]);
      chk($sformatf("R5 R6 R7 vec%0d high span", v), hi, VEC[v][5]);
    end

    // R1 disable part way through a low phase
    low_cnt  = 16'd12;
    high_cnt = 16'd6;
    wait_fall();
    wait_fall();
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R1 release on disable", {31'd0, drive_low}, 0);
    begin
      int act = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        act += int'(drive_low) + int'(rise) + int'(fall);
      end
      chk("R1 quiet while disabled", act, 0);
    end
    // R1 counters reset: full low phase after re-enable
    en = 1'b1;
    measure(0, 0, 12, lo, hi);
    chk("R1 full low after re-enable", lo, 13);
    chk("R5 high after re-enable", hi, 6);

    // R7 large value passes unclamped
    low_cnt = 16'd4;
    high_cnt = 16'd5;
    wait_fall();
    measure(0, 0, 4, lo, hi);
    chk("R7 high of 5 unclamped", hi, 5);
    chk("R3 low of 4", lo, 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule